// File: doc/BRIEF.md
# MDIO Management Master

This block runs single register transactions from a host to an external PHY over the two-wire management link. The host sets the operation (read or write), a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data, and then pulses a start input for one clock. The block divides the system clock to make the management clock and sends the whole frame. When the frame is over it pulses `done_o`. For a read, it presents the register value on `rd_data_o`.

The data line goes through three separate signals: a driven value, an output enable and a sampled input. The pad can therefore be tri-stated outside the block. On a read the block checks whether the PHY pulls the line low during the turnaround. If it does not, the block clocks out a run of recovery cycles with the line released and ends the transaction with an error. Both reads and writes end with a few trailing clock cycles, so that the PHY's serial interface is left in a known state.

Top module: `mdio_master`

## Requirements
- R1: While reset is asserted, and after it is released, `mdc_o` is low, `mdio_oe_o` is low, `busy_o` is low and `done_o` is low. A reset that arrives during a frame abandons the frame and returns the block to these values.
- R2: Every frame begins with 32 management-clock cycles during which the data line is driven to 1.
- R3: After the preamble, the block drives the start pattern 0,1 and then the opcode. The opcode is 1,0 for a read and 0,1 for a write.
- R4: After the opcode, the block drives the PHY address and then the register address, 5 bits each, most significant bit first.
- R5: While the block drives the data line, the line changes only while `mdc_o` is low. It holds its value for the whole high phase.
- R6: A write drives the turnaround bits 1,0 and then the 16 data bits, most significant bit first. The block then releases the line and gives one more clock cycle. A write frame has 65 clock cycles and 64 driven bits.
- R7: A read releases the line from the turnaround onward. It captures 16 bits, most significant bit first, each one sampled at the end of the high phase of `mdc_o`. Two trailing clock cycles follow, for 65 cycles in all. `rd_data_o` then holds the captured value and `err_o` stays low.
- R8: If a read finds the line high at the end of the first turnaround cycle, the block gives 32 more clock cycles with the line released, for 79 cycles in all. It then raises `err_o` together with `done_o`, and leaves `rd_data_o` unchanged.
- R9: Each half of `mdc_o` lasts HALF_CLKS system clocks. `done_o` rises 2·HALF_CLKS·(cycle count) clocks after the clock edge that accepts start.
- R10: `busy_o` is high from the accepting edge until `done_o`. `done_o` is a one-clock pulse. A start that arrives while busy has no effect on the frame, including its operation and addresses.
- R11: Whenever the block is idle, `mdc_o` is low and the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-clock request to begin a transaction |
| op_read_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wr_data_i | input | 16 | Data for a write |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-clock pulse at the end of a transaction |
| err_o | output | 1 | Pulses with done_o when a read got no PHY response |
| rd_data_o | output | 16 | Last value read successfully |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Driven value of the data line |
| mdio_oe_o | output | 1 | Output enable for the data line |
| mdio_i | input | 1 | Sampled value of the data line |

## Verification
The hardest situation to reach from the ports is the turnaround decision. It depends on the line level at one particular clock edge, deep inside the frame. The bench contains a small PHY model that counts rising edges of `mdc_o` and drives the line on the falling edges. It can be told to stay silent, which leaves the line pulled high. This exercises both the data capture path and the recovery path, and in both cases the bench compares the frame length against the expected number of clocks. A second hard case is a start request that arrives mid-frame with different operands. The bench pulses start well inside a write and then checks that the captured bit stream and the frame length still match the original write.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int unsigned DATA_BITS  = 16;
  localparam int unsigned ADDR_BITS  = 5;
  localparam int unsigned SOF_SLOTS  = 2;
  localparam int unsigned OP_SLOTS   = 2;
  localparam int unsigned TA_SLOTS   = 2;
  localparam int unsigned RD_TA      = 1;
  localparam int unsigned WR_TAIL    = 1;
  localparam int unsigned RD_TAIL    = 2;
  localparam int unsigned FRAME_BITS = SOF_SLOTS + OP_SLOTS + 2*ADDR_BITS + TA_SLOTS + DATA_BITS;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_SOF,
    ST_OP,
    ST_PHY,
    ST_REG,
    ST_TA,
    ST_DATA,
    ST_TAIL,
    ST_RECOV
  } seq_state_t;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int unsigned HALF_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);

  localparam int unsigned HW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [HW-1:0] LAST = HW'(HALF_CLKS - 1);

  logic [HW-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == LAST);

  always_comb begin
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + HW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  output logic         msb_o
);

  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load_i)       sr_d = word_i;
    else if (shift_i) sr_d = {sr_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign msb_o = sr_q[W-1];

endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_i,
  input  logic         last_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);

  logic [W-1:0] sr_q, sr_d;
  logic [W-1:0] hold_q, hold_d;

  always_comb begin
    sr_d   = sr_q;
    hold_d = hold_q;
    if (shift_i) sr_d = {sr_q[W-2:0], bit_i};
    if (shift_i && last_i) hold_d = {sr_q[W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      hold_q <= '0;
    end else begin
      sr_q   <= sr_d;
      hold_q <= hold_d;
    end
  end

  assign data_o = hold_q;

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_SLOTS   = 32,
  parameter int unsigned RECOV_SLOTS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic op_read_i,
  input  logic tick_i,
  input  logic line_i,
  output logic busy_o,
  output logic phase_o,
  output logic drive_o,
  output logic pre_o,
  output logic load_o,
  output logic shift_o,
  output logic cap_o,
  output logic cap_last_o,
  output logic done_o,
  output logic err_o
);

  localparam int unsigned MAX_A    = (PRE_SLOTS > RECOV_SLOTS) ? PRE_SLOTS : RECOV_SLOTS;
  localparam int unsigned MAX_SLOT = (MAX_A > DATA_BITS) ? MAX_A : DATA_BITS;
  localparam int unsigned CW       = $clog2(MAX_SLOT + 1);

  seq_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          phase_q, phase_d;
  logic          rd_q, rd_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic [CW-1:0] len;
  logic          slot_end;
  logic          last_slot;

  always_comb begin
    unique case (state_q)
      ST_PRE:   len = CW'(PRE_SLOTS);
      ST_SOF:   len = CW'(SOF_SLOTS);
      ST_OP:    len = CW'(OP_SLOTS);
      ST_PHY:   len = CW'(ADDR_BITS);
      ST_REG:   len = CW'(ADDR_BITS);
      ST_TA:    len = rd_q ? CW'(RD_TA) : CW'(TA_SLOTS);
      ST_DATA:  len = CW'(DATA_BITS);
      ST_TAIL:  len = rd_q ? CW'(RD_TAIL) : CW'(WR_TAIL);
      ST_RECOV: len = CW'(RECOV_SLOTS);
      default:  len = CW'(1);
    endcase
  end

  assign slot_end  = tick_i && phase_q;
  assign last_slot = (cnt_q == (len - CW'(1)));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    phase_d = phase_q;
    rd_d    = rd_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    if (state_q == ST_IDLE) begin
      phase_d = 1'b0;
      cnt_d   = '0;
      if (start_i) begin
        state_d = ST_PRE;
        rd_d    = op_read_i;
      end
    end else begin
      if (tick_i) phase_d = !phase_q;
      if (slot_end) begin
        if (last_slot) begin
          cnt_d = '0;
          unique case (state_q)
            ST_PRE:   state_d = ST_SOF;
            ST_SOF:   state_d = ST_OP;
            ST_OP:    state_d = ST_PHY;
            ST_PHY:   state_d = ST_REG;
            ST_REG:   state_d = ST_TA;
            ST_TA:    state_d = (rd_q && line_i) ? ST_RECOV : ST_DATA;
            ST_DATA:  state_d = ST_TAIL;
            ST_TAIL: begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
            ST_RECOV: begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
              err_d   = 1'b1;
            end
            default:  state_d = ST_IDLE;
          endcase
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      phase_q <= 1'b0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      rd_q    <= rd_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign phase_o    = phase_q;
  assign pre_o      = (state_q == ST_PRE);
  assign drive_o    = (state_q inside {ST_PRE, ST_SOF, ST_OP, ST_PHY, ST_REG})
                   || (!rd_q && (state_q inside {ST_TA, ST_DATA}));
  assign load_o     = (state_q == ST_IDLE) && start_i;
  assign shift_o    = slot_end && (state_q inside {ST_SOF, ST_OP, ST_PHY, ST_REG, ST_TA, ST_DATA});
  assign cap_o      = slot_end && rd_q && (state_q == ST_DATA);
  assign cap_last_o = last_slot;
  assign done_o     = done_q;
  assign err_o      = err_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned HALF_CLKS   = 3,
  parameter int unsigned PRE_SLOTS   = 32,
  parameter int unsigned RECOV_SLOTS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        op_read_i,
  input  logic [4:0]  phy_addr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] wr_data_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [15:0] rd_data_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);

  logic tick, busy, phase, drive, pre, load, shift, cap, cap_last, tx_msb;
  logic [FRAME_BITS-1:0] frame_word;

  assign frame_word = {2'b01,
                       (op_read_i ? 2'b10 : 2'b01),
                       phy_addr_i,
                       reg_addr_i,
                       2'b10,
                       wr_data_i};

  mdio_clk_div #(.HALF_CLKS(HALF_CLKS)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy),
    .tick_o (tick)
  );

  mdio_frame_seq #(.PRE_SLOTS(PRE_SLOTS), .RECOV_SLOTS(RECOV_SLOTS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .op_read_i  (op_read_i),
    .tick_i     (tick),
    .line_i     (mdio_i),
    .busy_o     (busy),
    .phase_o    (phase),
    .drive_o    (drive),
    .pre_o      (pre),
    .load_o     (load),
    .shift_o    (shift),
    .cap_o      (cap),
    .cap_last_o (cap_last),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  mdio_tx_shift #(.W(FRAME_BITS)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .word_i  (frame_word),
    .shift_i (shift),
    .msb_o   (tx_msb)
  );

  mdio_rx_shift #(.W(DATA_BITS)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (cap),
    .last_i  (cap_last),
    .bit_i   (mdio_i),
    .data_o  (rd_data_o)
  );

  assign busy_o    = busy;
  assign mdc_o     = phase;
  assign mdio_oe_o = drive;
  assign mdio_o    = drive && (pre || tx_msb);

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int unsigned HALF_CLKS = 3
) (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic mdc_o,
  input logic mdio_o,
  input logic mdio_oe_o
);

  logic        prev_mdc;
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_mdc <= 1'b0;
      run_len  <= 0;
    end else begin
      prev_mdc <= mdc_o;
      run_len  <= (mdc_o != prev_mdc || !busy_o) ? 0 : run_len + 1;
    end
  end

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mdc_o && !mdio_oe_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  // R5
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_o && mdio_oe_o) |-> $stable(mdio_o));

  // R9
  half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mdc_o && prev_mdc) |-> (run_len == HALF_CLKS - 1));

endmodule

bind mdio_master mdio_master_chk #(.HALF_CLKS(HALF_CLKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;

  localparam int H = 3;

  logic        clk, rst_n, start, op_rd, mdio_i;
  logic [4:0]  phy, rga;
  logic [15:0] wdat;
  logic        busy, done, err, mdc, mdio_o, oe;
  logic [15:0] rdat;

  int errors = 0, checks = 0, cycles = 0;

  // monitor state
  logic        clr_mon, prev_m, hi_val, phy_on;
  logic [15:0] phy_val;
  logic [63:0] cap;
  int          rcnt, ndrv, hi_len, hi_bad, r5_viol;

  mdio_master #(.HALF_CLKS(H)) i_mdio_master (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_read_i(op_rd),
    .phy_addr_i(phy), .reg_addr_i(rga), .wr_data_i(wdat),
    .busy_o(busy), .done_o(done), .err_o(err), .rd_data_o(rdat),
    .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // fields: rd[27] present[26] phy[25:21] reg[20:16] data[15:0]
  localparam int NV = 6;
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 1'b0, 5'h01, 5'h00, 16'hA5C3},
    {1'b1, 1'b1, 5'h1F, 5'h1F, 16'h8001},
    {1'b0, 1'b0, 5'h10, 5'h01, 16'h0000},
    {1'b1, 1'b1, 5'h00, 5'h10, 16'h7E5A},
    {1'b1, 1'b0, 5'h03, 5'h02, 16'h1234},
    {1'b1, 1'b1, 5'h0A, 5'h15, 16'hFFFF}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // PHY model and line monitor, all sampled away from the active edge
  always @(negedge clk) begin
    if (!rst_n || clr_mon) begin
      rcnt = 0; ndrv = 0; cap = '0; mdio_i = 1'b1; hi_len = 0;
      if (!rst_n) begin hi_bad = 0; r5_viol = 0; end
    end else begin
      if (mdc && !prev_m) begin
        rcnt++;
        hi_len = 1;
        if (oe) begin cap = {cap[62:0], mdio_o}; ndrv++; hi_val = mdio_o; end
      end else if (mdc && prev_m) begin
        hi_len++;
        if (oe && mdio_o != hi_val) r5_viol++;
      end else if (!mdc && prev_m) begin
        if (hi_len != H) hi_bad++;
        if (phy_on) begin
          if (rcnt == 46) mdio_i = 1'b0;
          else if (rcnt >= 47 && rcnt <= 62) mdio_i = phy_val[15-(rcnt-47)];
          else mdio_i = 1'b1;
        end else mdio_i = 1'b1;
      end
    end
    prev_m = mdc;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  // Runs one frame; inject>0 pulses a conflicting start at that count.
  task automatic run_frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] d, input logic present, input int inject,
                           output int n);
    @(negedge clk);
    op_rd = rd; phy = pa; rga = ra; wdat = rd ? 16'h0 : d;
    phy_on = rd && present; phy_val = d;
    clr_mon = 1'b1; start = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) start = 1'b0;
      if (n == 2) clr_mon = 1'b0;
      if (inject > 0 && n == inject) begin
        // R10: busy during frame, then a start with other operands
        check(busy === 1'b1, "R10 busy mid-frame", busy, 1);
        start = 1'b1; op_rd = ~rd; phy = ~pa; rga = ~ra; wdat = ~d;
      end
      if (inject > 0 && n == inject + 1) start = 1'b0;
    end while (!done && n < 2000);
  endtask

  initial begin
    int n, slots;
    logic rd, pres;
    logic [4:0] pa, ra;
    logic [15:0] d, last_rd;
    logic [45:0] exp_rd_bits;
    logic [63:0] exp_wr_bits;

    rst_n = 1'b0; start = 0; op_rd = 0; phy = 0; rga = 0; wdat = 0;
    clr_mon = 0; phy_on = 0; phy_val = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check({mdc, oe, busy, done} === 4'b0, "R1 in reset", {mdc, oe, busy, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 after release
    check({mdc, oe, busy, done} === 4'b0, "R1 after reset", {mdc, oe, busy, done}, 0);
    last_rd = 16'h0;

    for (int i = 0; i < NV; i++) begin
      {rd, pres, pa, ra, d} = VEC[i];
      run_frame(rd, pa, ra, d, pres, 0, n);
      slots = !rd ? 65 : (pres ? 65 : 79);
      // R9 / R6 / R7 / R8 frame length
      check(n == 2*H*slots + 1, $sformatf("R9 frame clocks v%0d", i), n, 2*H*slots + 1);
      check(rcnt == slots, $sformatf("R6 R7 R8 mdc cycles v%0d", i), rcnt, slots);
      if (!rd) begin
        exp_wr_bits = {32'hFFFF_FFFF, 4'b0101, pa, ra, 2'b10, d};
        // R2 R3 R4 R6 write bit stream
        check(ndrv == 64, $sformatf("R6 driven bits v%0d", i), ndrv, 64);
        check(cap == exp_wr_bits, $sformatf("R2 R3 R4 R6 write frame v%0d", i), cap, exp_wr_bits);
        check(err === 1'b0, $sformatf("R6 no err v%0d", i), err, 0);
      end else begin
        exp_rd_bits = {32'hFFFF_FFFF, 4'b0110, pa, ra};
        // R2 R3 R4 R7 read header, line released from turnaround
        check(ndrv == 46, $sformatf("R7 driven bits v%0d", i), ndrv, 46);
        check(cap[45:0] == exp_rd_bits, $sformatf("R2 R3 R4 read header v%0d", i), cap[45:0], exp_rd_bits);
        if (pres) begin
          last_rd = d;
          check(err === 1'b0, $sformatf("R7 no err v%0d", i), err, 0);
        end else begin
          check(err === 1'b1, $sformatf("R8 err v%0d", i), err, 1);
        end
        // R7 captured data / R8 unchanged on error
        check(rdat == last_rd, $sformatf("R7 R8 rd_data v%0d", i), rdat, last_rd);
      end
      check(busy === 1'b0, $sformatf("R10 busy low at done v%0d", i), busy, 0);
      @(negedge clk);
      check(done === 1'b0, $sformatf("R10 done one clock v%0d", i), done, 0);
      // R11 idle quiet
      check({mdc, oe} === 2'b00, $sformatf("R11 idle v%0d", i), {mdc, oe}, 0);
    end

    // R5 and R9 over all frames so far
    check(r5_viol == 0, "R5 data stable while mdc high", r5_viol, 0);
    check(hi_bad == 0, "R9 high phase length", hi_bad, 0);

    // R10: start while busy is ignored
    run_frame(1'b0, 5'h15, 5'h0A, 16'h3C96, 1'b0, 150, n);
    check(n == 2*H*65 + 1, "R10 ignored start frame clocks", n, 2*H*65 + 1);
    exp_wr_bits = {32'hFFFF_FFFF, 4'b0101, 5'h15, 5'h0A, 2'b10, 16'h3C96};
    check(cap == exp_wr_bits, "R10 ignored start frame bits", cap, exp_wr_bits);
    @(negedge clk);
    check(busy === 1'b0, "R10 no second frame", busy, 0);

    // R1: reset mid-frame
    @(negedge clk);
    op_rd = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check({mdc, oe, busy, done} === 4'b0, "R1 reset mid-frame", {mdc, oe, busy, done}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(busy === 1'b0, "R1 idle after mid-frame reset", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule